// File: doc/BRIEF.md
# Sampling Converter Control and Parallel Readout

This block is the digital front end of a successive-approximation converter. It watches four active-low control inputs: select, convert, read and power-down. From them it starts conversions in an external sequencer, drives an active-low busy status and presents the latest 16-bit result on a parallel bus. The bus is modelled as a data word plus an output-enable, so the three-state drivers sit outside the block.

A single select pin does two jobs. While power-down is inactive, select qualifies the convert and read inputs. While power-down is asserted, select picks the depth of shutdown. Select low gives a light nap with a short wake-up, and select high gives a deep sleep whose wake-up lasts much longer. Both wake-up delays are clock-cycle counts set by parameters. A convert request that arrives before the block is ready again is dropped.

The convert input is asynchronous. It passes through a two-flop synchroniser before its falling edge is detected. The select, read and power-down inputs are taken to be synchronous to the clock.

Top module: `adc_ctrl_top`

## Requirements
- R1: After reset the block is in the run state, with `pwr_mode` = 2'b00 and `busy_n` = 1, and the stored result is zero. With `cs_n` and `rd_n` both low, the bus therefore reads 16'h0000.
- R2: A conversion is accepted when the synchronised `convst_n` has a falling edge, `cs_n` is low, the block is in the run state with `shdn_n` high, and no conversion is in progress. Say `convst_n` is first sampled low at clock edge k. Then `busy_n` goes low and `eng_start` pulses high for one cycle after edge k+2.
- R3: `busy_n` stays low until `eng_done` is sampled high. On that edge `busy_n` returns high and `eng_code` is stored as the result, so the new result is on the bus when `busy_n` rises.
- R4: `bus_oe` is high only when both `cs_n` and `rd_n` are low. When `bus_oe` is high, `bus_data` carries the stored result. When `bus_oe` is low, `bus_data` is all zeros.
- R5: A falling edge of `convst_n` while `cs_n` is high starts nothing.
- R6: A falling edge of `convst_n` during a conversion is discarded. It is not held for later.
- R7: An `eng_done` pulse while no conversion is in progress leaves the stored result and `busy_n` unchanged.
- R8: When `shdn_n` goes low with `cs_n` low, the block enters nap (`pwr_mode` = 2'b01). When `shdn_n` goes low with `cs_n` high, it enters sleep (2'b10). Nap moves to sleep if `cs_n` rises while `shdn_n` is low. Sleep stays sleep, whatever `cs_n` does, until `shdn_n` rises.
- R9: If `shdn_n` goes low during a conversion, the block stays in the run state until the conversion finishes. It enters shutdown on the next edge after that.
- R10: When `shdn_n` rises, `pwr_mode` reads 2'b11 (waking) for NAP_WAKE_CYC cycles after a nap, or for SLEEP_WAKE_CYC cycles after a sleep. It then returns to 2'b00. Convert requests made while in shutdown or while waking are ignored.
- R11: With `rd_n` tied to `convst_n`, pulling both low shows the previous result on the bus for the whole conversion. The new result replaces it when `busy_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Select: qualifies convert and read; picks the shutdown depth |
| convst_n | input | 1 | Convert request, asynchronous; its falling edge starts a conversion |
| rd_n | input | 1 | Read enable, active low |
| shdn_n | input | 1 | Power-down request, active low |
| eng_start | output | 1 | One-cycle start pulse to the conversion sequencer |
| eng_done | input | 1 | Sequencer reports that the result is ready |
| eng_code | input | 16 | Result word from the sequencer |
| busy_n | output | 1 | Low while a conversion is in progress |
| bus_data | output | 16 | Result word to the bus drivers (zero when not enabled) |
| bus_oe | output | 1 | Enable for the bus drivers |
| pwr_mode | output | 2 | Power state: 00 run, 01 nap, 10 sleep, 11 waking |

## Verification
The hardest cases to reach from the ports are the ones where two controls interact: power-down arriving in the middle of a conversion, and a nap turning into a sleep before the wake-up starts. For the first, the stimulus starts a conversion, holds off the modelled sequencer's done pulse, and drops `shdn_n` while `busy_n` is low. For the second, it raises `cs_n` during a nap and then confirms that wake-up takes the long sleep count. The wake windows are checked on their exact first and last waking cycles. Convert pulses are issued inside each window to show that they are refused.

// File: rtl/adc_ctrl_pkg.sv
// Shared types for the converter control block.
// Assumes: the pw_state_t encoding is visible on the pwr_mode port.
package adc_ctrl_pkg;
    typedef enum logic [1:0] {
        PW_RUN   = 2'b00,
        PW_NAP   = 2'b01,
        PW_SLEEP = 2'b10,
        PW_WAKE  = 2'b11
    } pw_state_t;
endpackage

// File: rtl/cvst_sync.sv
// Synchronises the asynchronous convert request and flags its falling edge.
// Assumes: STAGES >= 2, and the request idles high.
module cvst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    output logic fall_o
);
    logic [STAGES-1:0] sh;
    logic              last;

    // shift the request through the synchroniser and keep one older copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '1;
            last <= 1'b1;
        end else begin
            sh   <= {sh[STAGES-2:0], req_n};
            last <= sh[STAGES-1];
        end
    end

    assign fall_o = last & ~sh[STAGES-1];
endmodule

// File: rtl/pwr_mgr.sv
// Power-state sequencer: run, nap, sleep and a counted wake-up.
// Assumes: shdn_n and cs_n are synchronous, and both wake counts are >= 1.
// Shutdown is held off while a conversion is running.
module pwr_mgr
    import adc_ctrl_pkg::*;
#(
    parameter int NAP_WAKE_CYC   = 50,
    parameter int SLEEP_WAKE_CYC = 40_000_000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      shdn_n,
    input  logic      cs_n,
    input  logic      conv_busy,
    output pw_state_t state,
    output logic      conv_ok
);
    localparam int MAXW  = (SLEEP_WAKE_CYC > NAP_WAKE_CYC) ? SLEEP_WAKE_CYC : NAP_WAKE_CYC;
    localparam int CNT_W = $clog2(MAXW + 1);

    logic [CNT_W-1:0] cnt;
    logic             deep;

    // state transitions and wake-up countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PW_RUN;
            cnt   <= '0;
            deep  <= 1'b0;
        end else begin
            case (state)
                PW_RUN: if (!shdn_n && !conv_busy) begin
                    state <= cs_n ? PW_SLEEP : PW_NAP;
                    deep  <= cs_n;
                end
                PW_NAP: if (shdn_n) begin
                    state <= PW_WAKE;
                    cnt   <= CNT_W'(NAP_WAKE_CYC - 1);
                end else if (cs_n) begin
                    state <= PW_SLEEP;
                    deep  <= 1'b1;
                end
                PW_SLEEP: if (shdn_n) begin
                    state <= PW_WAKE;
                    cnt   <= CNT_W'(SLEEP_WAKE_CYC - 1);
                end
                default: if (!shdn_n) begin
                    if (deep || cs_n) begin
                        state <= PW_SLEEP;
                        deep  <= 1'b1;
                    end else begin
                        state <= PW_NAP;
                    end
                end else if (cnt == '0) begin
                    state <= PW_RUN;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            endcase
        end
    end

    assign conv_ok = (state == PW_RUN) && shdn_n;

    // R8
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PW_SLEEP && !shdn_n) |=> state == PW_SLEEP);

    // R10
    run_from_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PW_RUN && $past(state) != PW_RUN && $past(rst_n)) |-> $past(state) == PW_WAKE);
endmodule

// File: rtl/conv_ctl.sv
// Conversion handshake: accepts a start, drives busy, captures the result.
// Assumes: the sequencer raises done once per start. Requests seen while
// busy are dropped, not queued.
module conv_ctl #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fall,
    input  logic          cs_n,
    input  logic          conv_ok,
    input  logic          eng_done,
    input  logic [DW-1:0] eng_code,
    output logic          eng_start,
    output logic          busy_n,
    output logic [DW-1:0] result
);
    // accept a start when idle; finish and capture the result on done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_n    <= 1'b1;
            eng_start <= 1'b0;
            result    <= '0;
        end else begin
            eng_start <= 1'b0;
            if (busy_n) begin
                if (fall && !cs_n && conv_ok) begin
                    busy_n    <= 1'b0;
                    eng_start <= 1'b1;
                end
            end else if (eng_done) begin
                busy_n <= 1'b1;
                result <= eng_code;
            end
        end
    end

    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_n && !eng_done) |=> !busy_n);

    // R5
    start_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> $past(!cs_n));

    // R6
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> $past(busy_n));

    // R7
    stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n && eng_done) |=> $stable(result));
endmodule

// File: rtl/adc_ctrl_top.sv
// Converter control top: synchroniser, power sequencer, conversion handshake
// and bus gating. Assumes the select, read and power-down inputs are
// synchronous. The bus is a data word plus an enable, not a true tristate.
module adc_ctrl_top
    import adc_ctrl_pkg::*;
#(
    parameter int DW             = 16,
    parameter int SYNC_STAGES    = 2,
    parameter int NAP_WAKE_CYC   = 50,
    parameter int SLEEP_WAKE_CYC = 40_000_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          convst_n,
    input  logic          rd_n,
    input  logic          shdn_n,
    output logic          eng_start,
    input  logic          eng_done,
    input  logic [DW-1:0] eng_code,
    output logic          busy_n,
    output logic [DW-1:0] bus_data,
    output logic          bus_oe,
    output logic [1:0]    pwr_mode
);
    logic          fall;
    logic          conv_ok;
    pw_state_t     pstate;
    logic [DW-1:0] result;

    cvst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .req_n(convst_n), .fall_o(fall)
    );

    pwr_mgr #(.NAP_WAKE_CYC(NAP_WAKE_CYC), .SLEEP_WAKE_CYC(SLEEP_WAKE_CYC)) u_pwr (
        .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .cs_n(cs_n),
        .conv_busy(~busy_n), .state(pstate), .conv_ok(conv_ok)
    );

    conv_ctl #(.DW(DW)) u_conv (
        .clk(clk), .rst_n(rst_n), .fall(fall), .cs_n(cs_n), .conv_ok(conv_ok),
        .eng_done(eng_done), .eng_code(eng_code), .eng_start(eng_start),
        .busy_n(busy_n), .result(result)
    );

    // bus gating: drive the result only while selected and read
    always_comb begin
        bus_oe   = ~cs_n & ~rd_n;
        bus_data = bus_oe ? result : '0;
    end

    assign pwr_mode = pstate;

    // R10
    start_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> $past(conv_ok));
endmodule

// File: tb/sim_adc_ctrl_top.sv
module sim_adc_ctrl_top;
    localparam int NAPW = 50;
    localparam int SLPW = 600;
    localparam int LAT  = 20;

    logic clk = 1'b0;
    logic rst_n, cs_n, convst_n, rd_n, shdn_n;
    logic eng_start, eng_done, busy_n, bus_oe;
    logic [15:0] eng_code, bus_data;
    logic [1:0]  pwr_mode;

    int n_chk = 0, n_bad = 0, n_start = 0;
    logic spur = 1'b0;
    logic [15:0] eng_q[$];
    logic [15:0] exp_q[$];

    always #2 clk = ~clk;

    adc_ctrl_top #(.NAP_WAKE_CYC(NAPW), .SLEEP_WAKE_CYC(SLPW)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .convst_n(convst_n), .rd_n(rd_n),
        .shdn_n(shdn_n), .eng_start(eng_start), .eng_done(eng_done),
        .eng_code(eng_code), .busy_n(busy_n), .bus_data(bus_data),
        .bus_oe(bus_oe), .pwr_mode(pwr_mode)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_busy(input logic val);
        int g = 0;
        while (busy_n !== val && g < 3000) begin
            tick(1);
            g++;
        end
        check_eq("R3 busy_n reached level", {31'd0, busy_n}, {31'd0, val});
    endtask

    task automatic pulse_cv();
        convst_n = 1'b0;
        tick(2);
        convst_n = 1'b1;
    endtask

    // driver: queues the expected result and runs one conversion
    task automatic do_conv(input logic [15:0] code);
        eng_q.push_back(code);
        exp_q.push_back(code);
        pulse_cv();
        wait_busy(1'b0);
        wait_busy(1'b1);
    endtask

    // sequencer model: answers each start after LAT cycles
    initial begin
        int cnt = 0;
        eng_done = 1'b0;
        eng_code = '0;
        forever begin
            @(negedge clk);
            eng_done = 1'b0;
            if (spur) begin
                eng_done = 1'b1;
                eng_code = 16'hDEAD;
                spur = 1'b0;
            end
            if (eng_start === 1'b1) begin
                n_start++;
                cnt = LAT;
            end else if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    eng_done = 1'b1;
                    eng_code = (eng_q.size() > 0) ? eng_q.pop_front() : 16'hBAD0;
                end
            end
        end
    end

    // monitor: compares the bus with the scoreboard on each busy rise
    initial begin
        logic prev = 1'b1;
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1 && busy_n === 1'b1 && prev === 1'b0) begin
                if (exp_q.size() == 0) begin
                    check_eq("R3 unexpected completion", 32'd1, 32'd0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check_eq("R3 result on bus at busy rise", {16'd0, bus_data}, {16'd0, e});
                end
            end
            prev = busy_n;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int s0;
        cs_n = 1; rd_n = 1; convst_n = 1; shdn_n = 1; rst_n = 0;
        tick(3);
        rst_n = 1;
        tick(1);
        // R1 reset state
        check_eq("R1 busy_n after reset", {31'd0, busy_n}, 32'd1);
        check_eq("R1 pwr_mode after reset", {30'd0, pwr_mode}, 32'd0);
        check_eq("R1 bus_oe deselected", {31'd0, bus_oe}, 32'd0);
        cs_n = 0; rd_n = 0;
        tick(1);
        check_eq("R1 bus reads zero result", {16'd0, bus_data}, 32'd0);

        // R2 exact start latency
        eng_q.push_back(16'h1234);
        exp_q.push_back(16'h1234);
        convst_n = 0;
        tick(2);
        check_eq("R2 busy_n still high after two edges", {31'd0, busy_n}, 32'd1);
        tick(1);
        check_eq("R2 busy_n low after third edge", {31'd0, busy_n}, 32'd0);
        check_eq("R2 eng_start pulse", {31'd0, eng_start}, 32'd1);
        convst_n = 1;
        wait_busy(1'b1);

        // R2 R3 several codes
        do_conv(16'h8000);
        do_conv(16'h7FFF);
        do_conv(16'hFFFF);
        do_conv(16'h0001);

        // R4 bus gating
        rd_n = 1; tick(1);
        check_eq("R4 oe low with rd_n high", {31'd0, bus_oe}, 32'd0);
        check_eq("R4 data zero with rd_n high", {16'd0, bus_data}, 32'd0);
        cs_n = 1; rd_n = 0; tick(1);
        check_eq("R4 oe low with cs_n high", {31'd0, bus_oe}, 32'd0);
        cs_n = 0; tick(1);
        check_eq("R4 data driven when enabled", {16'd0, bus_data}, 32'h0001);

        // R5 convert ignored while deselected
        s0 = n_start;
        cs_n = 1; pulse_cv(); tick(8);
        check_eq("R5 no busy while deselected", {31'd0, busy_n}, 32'd1);
        check_eq("R5 no start while deselected", n_start, s0);
        cs_n = 0; tick(1);

        // R6 edge during busy discarded
        s0 = n_start;
        eng_q.push_back(16'hA55A);
        exp_q.push_back(16'hA55A);
        pulse_cv();
        wait_busy(1'b0);
        tick(3);
        pulse_cv();
        wait_busy(1'b1);
        tick(10);
        check_eq("R6 one start only", n_start, s0 + 1);
        check_eq("R6 busy_n high afterwards", {31'd0, busy_n}, 32'd1);

        // R7 stray done ignored
        spur = 1; tick(3);
        check_eq("R7 result unchanged", {16'd0, bus_data}, 32'hA55A);
        check_eq("R7 busy_n unchanged", {31'd0, busy_n}, 32'd1);

        // R11 read tied to convert
        rd_n = 1; tick(1);
        eng_q.push_back(16'h0F0F);
        exp_q.push_back(16'h0F0F);
        rd_n = 0; convst_n = 0;
        tick(1);
        check_eq("R11 previous result shown", {16'd0, bus_data}, 32'hA55A);
        wait_busy(1'b0);
        tick(5);
        check_eq("R11 previous result during conversion", {16'd0, bus_data}, 32'hA55A);
        wait_busy(1'b1);
        check_eq("R11 new result after busy rise", {16'd0, bus_data}, 32'h0F0F);
        convst_n = 1; tick(2);

        // R8 nap, R10 nap wake timing
        shdn_n = 0; tick(2);
        check_eq("R8 nap with cs_n low", {30'd0, pwr_mode}, 32'd1);
        s0 = n_start;
        pulse_cv(); tick(6);
        check_eq("R10 convert ignored in nap", n_start, s0);
        shdn_n = 1;
        tick(1);
        check_eq("R10 waking after nap", {30'd0, pwr_mode}, 32'd3);
        tick(NAPW - 1);
        check_eq("R10 still waking at last nap cycle", {30'd0, pwr_mode}, 32'd3);
        tick(1);
        check_eq("R10 run after nap wake", {30'd0, pwr_mode}, 32'd0);
        do_conv(16'h1111);

        // R8 nap to sleep, sleep hold, R10 sleep wake
        shdn_n = 0; tick(2);
        cs_n = 1; tick(2);
        check_eq("R8 nap becomes sleep", {30'd0, pwr_mode}, 32'd2);
        cs_n = 0; tick(2);
        check_eq("R8 sleep holds with cs_n low", {30'd0, pwr_mode}, 32'd2);
        shdn_n = 1;
        tick(NAPW + 5);
        check_eq("R10 still waking past nap time", {30'd0, pwr_mode}, 32'd3);
        s0 = n_start;
        pulse_cv(); tick(6);
        check_eq("R10 convert ignored while waking", n_start, s0);
        check_eq("R10 busy_n high while waking", {31'd0, busy_n}, 32'd1);
        tick(SLPW);
        check_eq("R10 run after sleep wake", {30'd0, pwr_mode}, 32'd0);
        do_conv(16'h2222);

        // R8 direct sleep with cs_n high
        cs_n = 1; shdn_n = 0; tick(2);
        check_eq("R8 sleep with cs_n high", {30'd0, pwr_mode}, 32'd2);
        cs_n = 0; shdn_n = 1; tick(SLPW + 2);
        check_eq("R10 run after direct sleep", {30'd0, pwr_mode}, 32'd0);

        // R9 shutdown deferred during conversion
        eng_q.push_back(16'h3333);
        exp_q.push_back(16'h3333);
        pulse_cv();
        wait_busy(1'b0);
        shdn_n = 0; tick(3);
        check_eq("R9 run held during conversion", {30'd0, pwr_mode}, 32'd0);
        check_eq("R9 conversion continues", {31'd0, busy_n}, 32'd0);
        wait_busy(1'b1);
        tick(1);
        check_eq("R9 nap after conversion ends", {30'd0, pwr_mode}, 32'd1);
        shdn_n = 1; tick(NAPW + 2);
        check_eq("R10 run after deferred nap", {30'd0, pwr_mode}, 32'd0);

        tick(4);
        check_eq("R3 scoreboard drained", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule